// File: doc/BRIEF.md
# Word-Serial AES-128 Encryption Core

This block encrypts one 128-bit block at a time under a 128-bit cipher key, with every wide transfer narrowed to 32-bit beats so the core needs few pins. One input channel carries a cipher-key word and a plaintext word side by side on each accepted beat. Four beats complete a load. The core then runs the ten AES rounds internally, one round per clock, and expands the key on the fly. The ciphertext leaves through an output channel as four 32-bit words.

Both channels use a valid/ready handshake. The core holds one block only. Once the fourth load beat is taken, the input channel stays closed until the last ciphertext word has been consumed. A fresh key must therefore be supplied with every block.

Top module: `aes_ws_core`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: A load is four accepted beats, where a beat is accepted on a rising edge with in_valid_i and in_ready_o both high. Beat k carries key bytes 4k..4k+3 on key_word_i and plaintext bytes 4k..4k+3 on data_word_i, with the lowest-numbered byte in bits 31:24.
- R3: From the cycle after the fourth load beat until the last ciphertext word is taken, in_ready_o is 0. Any in_valid_i activity in that time leaves the result unchanged.
- R4: out_valid_o first goes high exactly 10 clock cycles after the edge that accepted the fourth load beat.
- R5: The ciphertext appears as four words. Word k holds bytes 4k..4k+3, with the lowest-numbered byte in bits 31:24. The output advances to the next word only on an edge where out_valid_o and out_ready_i are both high.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_word_o stays unchanged.
- R7: The ciphertext is AES-128 encryption of the plaintext under the key. That means an initial key addition, then nine full rounds, then a final round without column mixing. Row shifting rotates row r of the state left by r bytes.
- R8: In the cycle after the fourth ciphertext word is taken, out_valid_o is 0 and in_ready_o is 1, and a new key and block can be loaded.
- R9: Idle cycles with in_valid_i low may fall between load beats without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Load beat offered |
| in_ready_o | output | 1 | Core can take a load beat |
| key_word_i | input | 32 | Cipher-key word of the current beat |
| data_word_i | input | 32 | Plaintext word of the current beat |
| out_valid_o | output | 1 | Ciphertext word available |
| out_ready_i | input | 1 | Consumer takes the current word |
| out_word_o | output | 32 | Ciphertext word |

## Verification
A wrong byte in the S-box, row shift, column mix or key schedule changes the state of the next round. AES diffusion spreads such an error across all four ciphertext words by the time out_valid_o rises, so every known-answer word comparison catches it. A round counter off by one moves the rise of out_valid_o away from the tenth cycle and is seen at once. A wrong output word counter shows up as a missing or extra word, or as in_ready_o failing to return in the cycle after the fourth word is taken. Stalled consumers and poked inputs during the busy period test whether the held state leaks across channel activity.

// File: rtl/aes_ws_pkg.sv
package aes_ws_pkg;
  localparam int WORD_W   = 32;
  localparam int BLK_W    = 128;
  localparam int N_WORDS  = BLK_W / WORD_W;
  localparam int N_ROUNDS = 10;
  localparam int CNT_W    = $clog2(N_WORDS);
  localparam int RND_W    = $clog2(N_ROUNDS + 1);

  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_SEND} phase_e;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  // inverse as a^254, zero maps to zero, then affine map
  function automatic logic [7:0] sbox_f(input logic [7:0] a);
    logic [7:0] sq, acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc ^ {acc[6:0], acc[7]} ^ {acc[5:0], acc[7:6]} ^
           {acc[4:0], acc[7:5]} ^ {acc[3:0], acc[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sub_word.sv
module aes_sub_word #(
  parameter int N_BYTES = 4
) (
  input  logic [8*N_BYTES-1:0] a_i,
  output logic [8*N_BYTES-1:0] s_o
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign s_o[8*b +: 8] = aes_ws_pkg::sbox_f(a_i[8*b +: 8]);
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_ws_pkg::*;
(
  input  logic [BLK_W-1:0] key_i,
  input  logic [7:0]       rcon_i,
  output logic [BLK_W-1:0] key_o
);
  logic [WORD_W-1:0] w0, w1, w2, w3, rot, sub, t, n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = key_i;
  assign rot = {w3[WORD_W-9:0], w3[WORD_W-1 -: 8]};

  aes_sub_word #(.N_BYTES(WORD_W/8)) u_sub (.a_i(rot), .s_o(sub));

  assign t  = sub ^ {rcon_i, {(WORD_W-8){1'b0}}};
  assign n0 = w0 ^ t;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign key_o = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_ws_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  localparam int NB = BLK_W / 8;
  localparam int NC = NB / 4;

  logic [BLK_W-1:0] sb, sh, mx;

  for (genvar c = 0; c < NC; c++) begin : g_sub
    aes_sub_word #(.N_BYTES(4)) u_sub (.a_i(state_i[32*c +: 32]), .s_o(sb[32*c +: 32]));
  end

  // byte n sits at [BLK_W-1-8n -: 8]; row r of column c is byte 4c+r
  always_comb begin
    sh = '0;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 4; r++)
        sh[BLK_W-1-8*(4*c+r) -: 8] = sb[BLK_W-1-8*(4*((c+r)%NC)+r) -: 8];
  end

  for (genvar c = 0; c < NC; c++) begin : g_mix
    logic [7:0] a0, a1, a2, a3;
    assign {a0, a1, a2, a3} = sh[BLK_W-1-32*c -: 32];
    assign mx[BLK_W-1-32*c -: 32] = {
      xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
      a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
      a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
      xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  end

  assign state_o = last_i ? sh : mx;
endmodule

// File: rtl/aes_ws_core.sv
module aes_ws_core
  import aes_ws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] key_word_i,
  input  logic [WORD_W-1:0] data_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RND_W-1:0] rnd_q;
  logic [7:0]       rcon_q;
  logic [BLK_W-1:0] st_q, rk_q;
  logic [BLK_W-1:0] ld_st, ld_key, rnd_out, nk;
  logic             in_fire, out_fire, last_rnd;

  assign in_ready_o  = (phase_q == PH_LOAD);
  assign out_valid_o = (phase_q == PH_SEND);
  assign out_word_o  = st_q[BLK_W-1 -: WORD_W];
  assign in_fire     = in_valid_i & in_ready_o;
  assign out_fire    = out_valid_o & out_ready_i;
  assign last_rnd    = (rnd_q == RND_W'(N_ROUNDS));

  assign ld_st  = {st_q[BLK_W-WORD_W-1:0], data_word_i};
  assign ld_key = {rk_q[BLK_W-WORD_W-1:0], key_word_i};

  aes_round    u_round (.state_i(st_q), .last_i(last_rnd), .state_o(rnd_out));
  aes_key_step u_key   (.key_i(rk_q), .rcon_i(rcon_q), .key_o(nk));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      rnd_q   <= '0;
      rcon_q  <= 8'h01;
      st_q    <= '0;
      rk_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: if (in_fire) begin
          rk_q  <= ld_key;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(N_WORDS-1)) begin
            st_q    <= ld_st ^ ld_key;  // initial key addition
            phase_q <= PH_RUN;
            rnd_q   <= RND_W'(1);
            rcon_q  <= 8'h01;
          end else begin
            st_q <= ld_st;
          end
        end
        PH_RUN: begin
          st_q   <= rnd_out ^ nk;
          rk_q   <= nk;
          rcon_q <= xt(rcon_q);
          rnd_q  <= rnd_q + 1'b1;
          if (last_rnd) begin
            phase_q <= PH_SEND;
            cnt_q   <= '0;
          end
        end
        PH_SEND: if (out_fire) begin
          st_q  <= {st_q[BLK_W-WORD_W-1:0], {WORD_W{1'b0}}};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(N_WORDS-1)) phase_q <= PH_LOAD;
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  p_ready_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o);
  p_load_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && cnt_q == CNT_W'(N_WORDS-1)) |=> !in_ready_o);
  p_first_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(phase_q == PH_RUN && last_rnd));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && cnt_q == CNT_W'(N_WORDS-1)) |=> (in_ready_o && !out_valid_o));
endmodule

// File: tb/aes_ws_core_tb.sv
`timescale 1ns/1ps
module aes_ws_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] key_word = '0, data_word = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_word;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  aes_ws_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .key_word_i(key_word), .data_word_i(data_word), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_word_o(out_word));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one block: gap exercises R9, stall R6, poke R3
  task automatic t_block(input logic [127:0] key, input logic [127:0] pt,
                         input logic [127:0] ct, input bit gap, input bit stall,
                         input bit poke);
    int n;
    logic [31:0] held;
    for (int i = 0; i < 4; i++) begin
      if (gap) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid  = 1'b1;
      key_word  = key[127-32*i -: 32];
      data_word = pt[127-32*i -: 32];
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R3", "in_ready after fourth beat", 32'(in_ready), 32'd0);
    if (poke) begin
      in_valid  = 1'b1;
      key_word  = 32'hdead_beef;
      data_word = 32'hcafe_f00d;
    end
    n = 0;
    while (!out_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == 10, "R4", "cycles to out_valid", 32'(n), 32'd10);
    for (int w = 0; w < 4; w++) begin
      if (stall) begin
        held = out_word;
        repeat (2) begin
          @(negedge clk);
          check(out_valid == 1'b1 && out_word == held, "R6", "word held under stall",
                out_word, held);
        end
      end
      check(out_valid == 1'b1, "R5", "out_valid for word", 32'(out_valid), 32'd1);
      check(out_word == ct[127-32*w -: 32], "R7", $sformatf("ciphertext word %0d", w),
            out_word, ct[127-32*w -: 32]);
      if (poke)
        check(in_ready == 1'b0, "R3", "in_ready while sending", 32'(in_ready), 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    in_valid = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "ready/valid after last word",
          {30'd0, in_ready, out_valid}, 32'd2);
  endtask

  initial begin
    t_reset();
    // R2 R7: byte order and known answers
    t_block(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, 1'b0, 1'b0);
    t_block(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
            128'h3925841d02dc09fbdc118597196a0b32, 1'b1, 1'b1, 1'b1);
    t_block(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b0, 1'b1, 1'b1);
    t_block(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1, 1'b0, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule